// File: doc/BRIEF.md
# Storage-Side Retrieval Task Dispatcher

This block sits between a host command queue and two execution paths inside a storage device. Each incoming command carries an opcode, a tag, an address and a byte count. The opcode selects one of three paths. Retrieval tasks (hash extraction, index search and analysis) are queued for a compute accelerator. Plain read and write commands go to the firmware data path. A configuration command rewrites the pointer to the accelerator's instruction and parameter region. Malformed commands are answered at once with an error code.

The accelerator runs one task at a time, in arrival order, from a small pending queue. An index search cannot start while a hash extraction is still in flight. When it does start, it is handed the most recent hash result as its search key. Every command returns exactly one completion that carries its tag and a status code. Accelerator tasks complete when the accelerator pulses done. All other commands complete in the cycle after they are accepted.

Top module: `taskDispatchTop`

## Requirements
- R1: Opcode 0xC0 queues a hash task, 0xC1 an index task and 0xC2 an analysis task. When the task starts, `accelStart` pulses for one cycle with `accelKind` = 0, 1 or 2 respectively and with the command's address and size. If the accelerator is idle and the queue is empty, the start is visible two cycles after the accepting edge.
- R2: Opcode 0x01 (write) and 0x02 (read) never start the accelerator. One cycle after acceptance, `fwValid` pulses with the command's address, size and tag, and `fwWrite` is 1 for 0x01. A status-0 completion is posted in the same cycle.
- R3: Opcode 0xC3 loads `cfgBase`/`cfgLen` from the command's address and size one cycle after acceptance and completes with status 0. Both outputs are unchanged by every other command.
- R4: Any other opcode completes one cycle after acceptance with status 1 and has no other effect.
- R5: A recognised command with a byte size of zero completes with status 2 and has no other effect.
- R6: An index command accepted before any hash command has been accepted completes with status 3. A queued index task never starts while a hash task is running, and it starts with `accelKey` equal to the `accelResult` of the most recently completed hash task. Non-index tasks start with a key of 0.
- R7: At most one accelerator task runs at a time. Queued tasks start in acceptance order, the next one no earlier than the cycle after the done pulse.
- R8: The pending queue holds 4 tasks. `cmdReady` is low when the queue is full or when `accelDone` is high, and is high otherwise.
- R9: `accelDone` while a task runs posts a status-0 completion one cycle later, carrying that task's tag. `accelDone` while idle posts nothing.
- R10: After reset, `accelStart`, `fwValid` and `cplValid` are low, `cfgBase`/`cfgLen` are 0 and `cmdReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Command can be accepted |
| cmdOpcode | input | 8 | Command opcode |
| cmdTag | input | TAG_W | Command tag echoed in completion |
| cmdAddr | input | ADDR_W | Physical data address |
| cmdSize | input | SIZE_W | Data size in bytes |
| accelStart | output | 1 | One-cycle task start pulse |
| accelKind | output | 2 | Task kind: 0 hash, 1 index, 2 analysis |
| accelAddr | output | ADDR_W | Task data address |
| accelSize | output | SIZE_W | Task byte size |
| accelKey | output | KEY_W | Search key for index tasks |
| accelDone | input | 1 | Running task finished |
| accelResult | input | KEY_W | Result of finished task |
| fwValid | output | 1 | One-cycle firmware request pulse |
| fwWrite | output | 1 | 1 write, 0 read |
| fwAddr | output | ADDR_W | Physical address for firmware |
| fwSize | output | SIZE_W | Byte size for firmware |
| fwTag | output | TAG_W | Tag for firmware request |
| cfgBase | output | ADDR_W | Instruction/parameter region base |
| cfgLen | output | SIZE_W | Instruction/parameter region length |
| cplValid | output | 1 | Completion pulse |
| cplTag | output | TAG_W | Completed command tag |
| cplStatus | output | 2 | 0 ok, 1 bad opcode, 2 zero size, 3 no hash key |

## Verification
The bench aims at the hold between hash and index. A design that ignored it would start the index with a stale or zero key, or would start while the hash was still running. It also fills the queue behind a slow accelerator and checks `cmdReady`. A design without the full check would overwrite queued tasks and lose their completions, and a design that did not drop ready on a done pulse would post two completions in one cycle and lose one of them. Spurious done pulses while idle, zero sizes, unknown opcodes and an index sent before any hash each target a specific decode bug: a stray completion, an accelerator start for a rejected command, or a configuration region overwritten by the wrong command.

// File: rtl/taskDispatchPkg.sv
package taskDispatchPkg;

  localparam logic [7:0] OP_HASH    = 8'hC0;
  localparam logic [7:0] OP_INDEX   = 8'hC1;
  localparam logic [7:0] OP_ANALYZE = 8'hC2;
  localparam logic [7:0] OP_CONFIG  = 8'hC3;
  localparam logic [7:0] OP_WRITE   = 8'h01;
  localparam logic [7:0] OP_READ    = 8'h02;

  typedef enum logic [1:0] {
    KIND_HASH    = 2'd0,
    KIND_INDEX   = 2'd1,
    KIND_ANALYZE = 2'd2
  } taskKindT;

  typedef enum logic [1:0] {
    ST_OK        = 2'd0,
    ST_BAD_OP    = 2'd1,
    ST_ZERO_SIZE = 2'd2,
    ST_NO_KEY    = 2'd3
  } cplStatusT;

  // strobes from control to datapath
  typedef struct packed {
    logic      push;     // enqueue accepted task
    logic      pop;      // start head task
    logic      fwFire;   // route to firmware
    logic      cfgLoad;  // update config region
    logic      cplImm;   // completion for accepted command
    logic      cplDone;  // completion for finished task
    cplStatusT status;
    taskKindT  kind;
  } ctrlStrobeT;

endpackage

// File: rtl/taskDispatchCtrl.sv
module taskDispatchCtrl
  import taskDispatchPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdOpcode,
  input  logic       sizeZero,
  input  logic       accelDone,
  input  logic       fifoFull,
  input  logic       fifoEmpty,
  output logic       cmdReady,
  output ctrlStrobeT strobe
);

  logic      busy;
  logic      hashSeen;
  logic      isTask, isFw, isCfg, accept;
  taskKindT  kind;
  cplStatusT status;

  always_comb begin
    isTask = 1'b0;
    isFw   = 1'b0;
    isCfg  = 1'b0;
    kind   = KIND_HASH;
    case (cmdOpcode)
      OP_HASH:    isTask = 1'b1;
      OP_INDEX:   begin isTask = 1'b1; kind = KIND_INDEX; end
      OP_ANALYZE: begin isTask = 1'b1; kind = KIND_ANALYZE; end
      OP_CONFIG:  isCfg = 1'b1;
      OP_WRITE,
      OP_READ:    isFw = 1'b1;
      default:    ;
    endcase

    if (!(isTask || isFw || isCfg))                    status = ST_BAD_OP;
    else if (sizeZero)                                 status = ST_ZERO_SIZE;
    else if (isTask && kind == KIND_INDEX && !hashSeen) status = ST_NO_KEY;
    else                                               status = ST_OK;
  end

  // done pulse owns the completion slot in its cycle
  assign cmdReady = !fifoFull && !accelDone;
  assign accept   = cmdValid && cmdReady;

  always_comb begin
    strobe.kind    = kind;
    strobe.status  = status;
    strobe.push    = accept && isTask && (status == ST_OK);
    strobe.fwFire  = accept && isFw && (status == ST_OK);
    strobe.cfgLoad = accept && isCfg && (status == ST_OK);
    strobe.cplImm  = accept && !(isTask && (status == ST_OK));
    strobe.cplDone = accelDone && busy;
    strobe.pop     = !fifoEmpty && !busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      hashSeen <= 1'b0;
    end else begin
      if (strobe.pop)          busy <= 1'b1;
      else if (strobe.cplDone) busy <= 1'b0;
      if (strobe.push && kind == KIND_HASH) hashSeen <= 1'b1;
    end
  end

endmodule

// File: rtl/taskDispatchPath.sv
module taskDispatchPath
  import taskDispatchPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 24,
  parameter int TAG_W  = 8,
  parameter int KEY_W  = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [7:0]        cmdOpcode,
  input  logic [TAG_W-1:0]  cmdTag,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [SIZE_W-1:0] cmdSize,
  input  logic [KEY_W-1:0]  accelResult,
  output logic              sizeZero,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic              accelStart,
  output logic [1:0]        accelKind,
  output logic [ADDR_W-1:0] accelAddr,
  output logic [SIZE_W-1:0] accelSize,
  output logic [KEY_W-1:0]  accelKey,
  output logic              fwValid,
  output logic              fwWrite,
  output logic [ADDR_W-1:0] fwAddr,
  output logic [SIZE_W-1:0] fwSize,
  output logic [TAG_W-1:0]  fwTag,
  output logic [ADDR_W-1:0] cfgBase,
  output logic [SIZE_W-1:0] cfgLen,
  output logic              cplValid,
  output logic [TAG_W-1:0]  cplTag,
  output logic [1:0]        cplStatus
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] qAddr [DEPTH];
  logic [SIZE_W-1:0] qSize [DEPTH];
  logic [TAG_W-1:0]  qTag  [DEPTH];
  taskKindT          qKind [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic [KEY_W-1:0]  hashKey;
  logic [TAG_W-1:0]  runTag;
  taskKindT          runKind;

  assign sizeZero  = (cmdSize == '0);
  assign fifoFull  = (count == FULL_CNT);
  assign fifoEmpty = (count == '0);

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      qAddr[wrPtr] <= cmdAddr;
      qSize[wrPtr] <= cmdSize;
      qTag[wrPtr]  <= cmdTag;
      qKind[wrPtr] <= strobe.kind;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      count      <= '0;
      accelStart <= 1'b0;
      accelKind  <= '0;
      accelAddr  <= '0;
      accelSize  <= '0;
      accelKey   <= '0;
      hashKey    <= '0;
      runTag     <= '0;
      runKind    <= KIND_HASH;
      fwValid    <= 1'b0;
      fwWrite    <= 1'b0;
      fwAddr     <= '0;
      fwSize     <= '0;
      fwTag      <= '0;
      cfgBase    <= '0;
      cfgLen     <= '0;
      cplValid   <= 1'b0;
      cplTag     <= '0;
      cplStatus  <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase

      accelStart <= strobe.pop;
      if (strobe.pop) begin
        accelKind <= qKind[rdPtr];
        accelAddr <= qAddr[rdPtr];
        accelSize <= qSize[rdPtr];
        accelKey  <= (qKind[rdPtr] == KIND_INDEX) ? hashKey : '0;
        runTag    <= qTag[rdPtr];
        runKind   <= qKind[rdPtr];
      end
      if (strobe.cplDone && runKind == KIND_HASH) hashKey <= accelResult;

      fwValid <= strobe.fwFire;
      if (strobe.fwFire) begin
        fwWrite <= (cmdOpcode == OP_WRITE);
        fwAddr  <= cmdAddr;
        fwSize  <= cmdSize;
        fwTag   <= cmdTag;
      end

      if (strobe.cfgLoad) begin
        cfgBase <= cmdAddr;
        cfgLen  <= cmdSize;
      end

      cplValid <= strobe.cplImm || strobe.cplDone;
      if (strobe.cplDone) begin
        cplTag    <= runTag;
        cplStatus <= ST_OK;
      end else if (strobe.cplImm) begin
        cplTag    <= cmdTag;
        cplStatus <= strobe.status;
      end
    end
  end

endmodule

// File: rtl/taskDispatchTop.sv
module taskDispatchTop
  import taskDispatchPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 24,
  parameter int TAG_W  = 8,
  parameter int KEY_W  = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [7:0]        cmdOpcode,
  input  logic [TAG_W-1:0]  cmdTag,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [SIZE_W-1:0] cmdSize,
  output logic              accelStart,
  output logic [1:0]        accelKind,
  output logic [ADDR_W-1:0] accelAddr,
  output logic [SIZE_W-1:0] accelSize,
  output logic [KEY_W-1:0]  accelKey,
  input  logic              accelDone,
  input  logic [KEY_W-1:0]  accelResult,
  output logic              fwValid,
  output logic              fwWrite,
  output logic [ADDR_W-1:0] fwAddr,
  output logic [SIZE_W-1:0] fwSize,
  output logic [TAG_W-1:0]  fwTag,
  output logic [ADDR_W-1:0] cfgBase,
  output logic [SIZE_W-1:0] cfgLen,
  output logic              cplValid,
  output logic [TAG_W-1:0]  cplTag,
  output logic [1:0]        cplStatus
);

  ctrlStrobeT strobe;
  logic       sizeZero, fifoFull, fifoEmpty;

  taskDispatchCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdOpcode (cmdOpcode),
    .sizeZero  (sizeZero),
    .accelDone (accelDone),
    .fifoFull  (fifoFull),
    .fifoEmpty (fifoEmpty),
    .cmdReady  (cmdReady),
    .strobe    (strobe)
  );

  taskDispatchPath #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .TAG_W(TAG_W), .KEY_W(KEY_W), .DEPTH(DEPTH)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cmdOpcode   (cmdOpcode),
    .cmdTag      (cmdTag),
    .cmdAddr     (cmdAddr),
    .cmdSize     (cmdSize),
    .accelResult (accelResult),
    .sizeZero    (sizeZero),
    .fifoFull    (fifoFull),
    .fifoEmpty   (fifoEmpty),
    .accelStart  (accelStart),
    .accelKind   (accelKind),
    .accelAddr   (accelAddr),
    .accelSize   (accelSize),
    .accelKey    (accelKey),
    .fwValid     (fwValid),
    .fwWrite     (fwWrite),
    .fwAddr      (fwAddr),
    .fwSize      (fwSize),
    .fwTag       (fwTag),
    .cfgBase     (cfgBase),
    .cfgLen      (cfgLen),
    .cplValid    (cplValid),
    .cplTag      (cplTag),
    .cplStatus   (cplStatus)
  );

endmodule

// File: rtl/taskDispatchChecker.sv
module taskDispatchChecker #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 24,
  parameter int TAG_W  = 8,
  parameter int KEY_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [7:0]        cmdOpcode,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [SIZE_W-1:0] cmdSize,
  input logic              accelStart,
  input logic [1:0]        accelKind,
  input logic [KEY_W-1:0]  accelKey,
  input logic              accelDone,
  input logic [KEY_W-1:0]  accelResult,
  input logic              fwValid,
  input logic [ADDR_W-1:0] fwAddr,
  input logic [ADDR_W-1:0] cfgBase,
  input logic [SIZE_W-1:0] cfgLen,
  input logic              cplValid,
  input logic [1:0]        cplStatus
);

  logic             chkBusy, chkHashDone;
  logic [1:0]       chkKind;
  logic [KEY_W-1:0] chkKey;
  logic             accepted, knownOp;

  assign accepted = cmdValid && cmdReady;
  assign knownOp  = (cmdOpcode == 8'hC0) || (cmdOpcode == 8'hC1) || (cmdOpcode == 8'hC2) ||
                    (cmdOpcode == 8'hC3) || (cmdOpcode == 8'h01) || (cmdOpcode == 8'h02);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkBusy     <= 1'b0;
      chkHashDone <= 1'b0;
      chkKind     <= '0;
      chkKey      <= '0;
    end else begin
      if (accelStart) begin
        chkBusy <= 1'b1;
        chkKind <= accelKind;
      end else if (accelDone) begin
        chkBusy <= 1'b0;
        if (chkBusy && chkKind == 2'd0) begin
          chkHashDone <= 1'b1;
          chkKey      <= accelResult;
        end
      end
    end
  end

  p_single_task_r7: assert property (@(posedge clk) disable iff (!rstN)
    accelStart |-> !chkBusy);

  p_index_key_r6: assert property (@(posedge clk) disable iff (!rstN)
    (accelStart && accelKind == 2'd1) |-> (chkHashDone && accelKey == chkKey));

  p_ready_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    accelDone |-> !cmdReady);

  p_done_cpl_r9: assert property (@(posedge clk) disable iff (!rstN)
    (accelDone && chkBusy) |=> (cplValid && cplStatus == 2'd0));

  p_bad_op_r4: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && !knownOp) |=> (cplValid && cplStatus == 2'd1 && !fwValid));

  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(accepted && cmdOpcode == 8'hC3 && cmdSize != '0) |=> ($stable(cfgBase) && $stable(cfgLen)));

  p_fw_route_r2: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && (cmdOpcode == 8'h01 || cmdOpcode == 8'h02) && cmdSize != '0)
      |=> (fwValid && fwAddr == $past(cmdAddr)));

endmodule

bind taskDispatchTop taskDispatchChecker #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .TAG_W(TAG_W), .KEY_W(KEY_W)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdValid    (cmdValid),
  .cmdReady    (cmdReady),
  .cmdOpcode   (cmdOpcode),
  .cmdAddr     (cmdAddr),
  .cmdSize     (cmdSize),
  .accelStart  (accelStart),
  .accelKind   (accelKind),
  .accelKey    (accelKey),
  .accelDone   (accelDone),
  .accelResult (accelResult),
  .fwValid     (fwValid),
  .fwAddr      (fwAddr),
  .cfgBase     (cfgBase),
  .cfgLen      (cfgLen),
  .cplValid    (cplValid),
  .cplStatus   (cplStatus)
);

// File: tb/sim_taskDispatchTop.sv
`timescale 1ns/1ps
module sim_taskDispatchTop;

  localparam int ADDR_W = 32;
  localparam int SIZE_W = 24;
  localparam int TAG_W  = 8;
  localparam int KEY_W  = 32;
  localparam int DEPTH  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdValid = 1'b0;
  logic              cmdReady;
  logic [7:0]        cmdOpcode = '0;
  logic [TAG_W-1:0]  cmdTag = '0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [SIZE_W-1:0] cmdSize = '0;
  logic              accelStart;
  logic [1:0]        accelKind;
  logic [ADDR_W-1:0] accelAddr;
  logic [SIZE_W-1:0] accelSize;
  logic [KEY_W-1:0]  accelKey;
  logic              accelDone = 1'b0;
  logic [KEY_W-1:0]  accelResult = '0;
  logic              fwValid, fwWrite;
  logic [ADDR_W-1:0] fwAddr;
  logic [SIZE_W-1:0] fwSize;
  logic [TAG_W-1:0]  fwTag;
  logic [ADDR_W-1:0] cfgBase;
  logic [SIZE_W-1:0] cfgLen;
  logic              cplValid;
  logic [TAG_W-1:0]  cplTag;
  logic [1:0]        cplStatus;

  always #4 clk = ~clk;

  taskDispatchTop #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .TAG_W(TAG_W), .KEY_W(KEY_W), .DEPTH(DEPTH)
  ) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOpcode(cmdOpcode), .cmdTag(cmdTag), .cmdAddr(cmdAddr), .cmdSize(cmdSize),
    .accelStart(accelStart), .accelKind(accelKind), .accelAddr(accelAddr),
    .accelSize(accelSize), .accelKey(accelKey), .accelDone(accelDone),
    .accelResult(accelResult), .fwValid(fwValid), .fwWrite(fwWrite),
    .fwAddr(fwAddr), .fwSize(fwSize), .fwTag(fwTag), .cfgBase(cfgBase),
    .cfgLen(cfgLen), .cplValid(cplValid), .cplTag(cplTag), .cplStatus(cplStatus)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model state
  logic [1:0]        qKind [8];
  logic [ADDR_W-1:0] qAddr [8];
  logic [SIZE_W-1:0] qSize [8];
  logic [TAG_W-1:0]  qTag  [8];
  int                qCount = 0;
  bit                mBusy = 1'b0;
  logic [1:0]        runKind = '0;
  logic [TAG_W-1:0]  runTag = '0;
  logic [KEY_W-1:0]  lastKey = '0;
  bit                hashSeen = 1'b0;
  int                countdown = 0;
  int                delayMax = 6;
  logic [ADDR_W-1:0] mCfgBase = '0;
  logic [SIZE_W-1:0] mCfgLen = '0;
  bit                eStartV = 0, eCplV = 0, eFwV = 0;
  logic [1:0]        eKind;
  logic [ADDR_W-1:0] eAddr;
  logic [SIZE_W-1:0] eSize;
  logic [KEY_W-1:0]  eKey;
  logic [TAG_W-1:0]  eCplTag;
  logic [1:0]        eCplStatus;
  bit                eFwWrite;
  logic [ADDR_W-1:0] eFwAddr;
  logic [SIZE_W-1:0] eFwSize;
  logic [TAG_W-1:0]  eFwTag;
  bit                accepted;
  logic [TAG_W-1:0]  nextTag = '0;
  int                fullSeen = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit isKnown(input logic [7:0] op);
    return op == 8'hC0 || op == 8'hC1 || op == 8'hC2 || op == 8'hC3 ||
           op == 8'h01 || op == 8'h02;
  endfunction

  function automatic logic [1:0] expStatus(input logic [7:0] op, input logic [SIZE_W-1:0] sz,
                                           input bit seen);
    if (!isKnown(op)) return 2'd1;
    if (sz == '0) return 2'd2;
    if (op == 8'hC1 && !seen) return 2'd3;
    return 2'd0;
  endfunction

  task automatic checkOutputs();
    chk(accelStart == eStartV, "R7", "accelStart", accelStart, eStartV);
    if (accelStart && eStartV) begin
      chk(accelKind == eKind, "R1", "accelKind", accelKind, eKind);
      chk(accelAddr == eAddr && accelSize == eSize, "R1", "accelAddr", accelAddr, eAddr);
      chk(accelKey == eKey, "R6", "accelKey", accelKey, eKey);
    end
    chk(cplValid == eCplV, "R9", "cplValid", cplValid, eCplV);
    if (cplValid && eCplV) begin
      chk(cplTag == eCplTag, "R9", "cplTag", cplTag, eCplTag);
      chk(cplStatus == eCplStatus, "R5", "cplStatus", cplStatus, eCplStatus);
    end
    chk(fwValid == eFwV, "R2", "fwValid", fwValid, eFwV);
    if (fwValid && eFwV)
      chk(fwWrite == eFwWrite && fwAddr == eFwAddr && fwSize == eFwSize && fwTag == eFwTag,
          "R2", "fwAddr", fwAddr, eFwAddr);
    chk(cfgBase == mCfgBase && cfgLen == mCfgLen, "R3", "cfgBase", cfgBase, mCfgBase);
  endtask

  task automatic cycle();
    bit willPop, doneNow;
    bit expReady;
    @(negedge clk);
    checkOutputs();
    // accelerator behaviour
    accelDone = 1'b0;
    if (mBusy) begin
      if (countdown == 0) begin
        accelDone   = 1'b1;
        accelResult = $urandom;
      end else countdown--;
    end else if ($urandom % 40 == 0) begin
      accelDone   = 1'b1;          // spurious pulse while idle (R9)
      accelResult = $urandom;
    end
    #1;
    expReady = (qCount < DEPTH) && !accelDone;
    chk(cmdReady == expReady, "R8", "cmdReady", cmdReady, expReady);
    if (qCount == DEPTH) fullSeen++;
    accepted = cmdValid && cmdReady;
    willPop  = (qCount > 0) && !mBusy;
    doneNow  = accelDone && mBusy;
    eStartV = 0; eCplV = 0; eFwV = 0;
    if (doneNow) begin
      eCplV = 1; eCplTag = runTag; eCplStatus = 2'd0;
      mBusy = 0;
      if (runKind == 2'd0) lastKey = accelResult;
    end
    if (willPop) begin
      eStartV = 1;
      eKind = qKind[0]; eAddr = qAddr[0]; eSize = qSize[0];
      eKey  = (qKind[0] == 2'd1) ? lastKey : '0;
      runKind = qKind[0]; runTag = qTag[0];
      for (int i = 0; i < 7; i++) begin
        qKind[i] = qKind[i+1]; qAddr[i] = qAddr[i+1];
        qSize[i] = qSize[i+1]; qTag[i]  = qTag[i+1];
      end
      qCount--;
      mBusy = 1;
      countdown = 1 + ($urandom % delayMax);
    end
    if (accepted) begin
      logic [1:0] st;
      st = expStatus(cmdOpcode, cmdSize, hashSeen);
      if (st == 2'd0 && (cmdOpcode == 8'hC0 || cmdOpcode == 8'hC1 || cmdOpcode == 8'hC2)) begin
        qKind[qCount] = cmdOpcode[1:0];
        qAddr[qCount] = cmdAddr;
        qSize[qCount] = cmdSize;
        qTag[qCount]  = cmdTag;
        qCount++;
        if (cmdOpcode == 8'hC0) hashSeen = 1;
      end else begin
        eCplV = 1; eCplTag = cmdTag; eCplStatus = st;
        if (st == 2'd0 && cmdOpcode == 8'hC3) begin
          mCfgBase = cmdAddr; mCfgLen = cmdSize;
        end
        if (st == 2'd0 && (cmdOpcode == 8'h01 || cmdOpcode == 8'h02)) begin
          eFwV = 1; eFwWrite = (cmdOpcode == 8'h01);
          eFwAddr = cmdAddr; eFwSize = cmdSize; eFwTag = cmdTag;
        end
      end
    end
    @(posedge clk);
    #1;
  endtask

  task automatic sendCmd(input logic [7:0] op, input logic [ADDR_W-1:0] addr,
                         input logic [SIZE_W-1:0] sz);
    cmdValid  = 1'b1;
    cmdOpcode = op;
    cmdAddr   = addr;
    cmdSize   = sz;
    cmdTag    = nextTag;
    nextTag++;
    accepted  = 1'b0;
    while (!accepted) cycle();
    cmdValid = 1'b0;
  endtask

  function automatic logic [7:0] randOp();
    int r;
    r = $urandom % 16;
    if (r < 4)  return 8'hC0;
    if (r < 7)  return 8'hC1;
    if (r < 9)  return 8'hC2;
    if (r == 9) return 8'hC3;
    if (r < 12) return 8'h01;
    if (r < 14) return 8'h02;
    if (r == 14) return 8'hC5;
    return 8'($urandom);
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R10: reset state
    @(negedge clk);
    chk(!accelStart && !fwValid && !cplValid, "R10", "pulses after reset",
        {accelStart, fwValid, cplValid}, 0);
    chk(cfgBase == '0 && cfgLen == '0, "R10", "cfg after reset", cfgBase, 0);
    chk(cmdReady == 1'b1, "R10", "cmdReady after reset", cmdReady, 1);
    @(posedge clk); #1;

    // directed corners
    sendCmd(8'hC1, 32'h1000, 24'd64);    // R6: index before any hash -> status 3
    sendCmd(8'h55, 32'h2000, 24'd16);    // R4: unknown opcode -> status 1
    sendCmd(8'hC0, 32'h3000, 24'd0);     // R5: zero size -> status 2
    sendCmd(8'hC3, 32'h0, 24'd0);        // R5/R3: zero-size config leaves region alone
    sendCmd(8'hC3, 32'hABCD_0000, 24'd4096);  // R3: config load
    sendCmd(8'h01, 32'h4000, 24'd512);   // R2: write
    sendCmd(8'h02, 32'h5000, 24'd256);   // R2: read
    // R8: slow accelerator, overfill queue; R6: index behind a hash
    delayMax = 40;
    sendCmd(8'hC0, 32'h6000, 24'd128);
    sendCmd(8'hC1, 32'h7000, 24'd32);
    sendCmd(8'hC2, 32'h8000, 24'd32);
    sendCmd(8'hC2, 32'h8100, 24'd32);
    sendCmd(8'hC1, 32'h8200, 24'd32);
    sendCmd(8'hC0, 32'h8300, 24'd32);
    sendCmd(8'hC1, 32'h8400, 24'd32);
    repeat (200) cycle();
    chk(fullSeen > 0, "R8", "queue reached full", fullSeen, 1);

    // R1..R9: constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      delayMax = (n % 500 < 100) ? 25 : 5;
      if ($urandom % 4 != 0)
        sendCmd(randOp(), $urandom, ($urandom % 10 == 0) ? 24'd0 : SIZE_W'($urandom));
      else
        cycle();
    end
    repeat (100) cycle();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule